// File: doc/BRIEF.md
# Multiprocessor-Capable Serial Frame Receiver

This block takes asynchronous serial frames from a single input line and presents each one to a host as a set of register-style outputs. The line is NRZ coded and idles high. Every frame opens with a low start bit, carries its data least significant bit first, and closes with a high stop bit. A one-cycle enable pulse, `os_tick`, paces the sampling at sixteen pulses per bit. The baud-rate generator that produces it lies outside the block.

The block has two modes. In normal mode the host chooses 7 or 8 data bits and may add a parity bit of either sense. In multiprocessor mode the frame always holds 8 data bits, followed by an address/data marker bit that the block captures in place of a parity check. Each completed frame sets a receive-full flag, and that flag drives an optional interrupt. Framing, parity and overrun problems are reported on sticky flags. The host clears receive-full by pulsing a read strobe and clears the error flags with a separate strobe.

Top module: `uart_mprx`

## Requirements
- R1: The block begins a frame when it sees a low level on the synchronised line while idle. It confirms the start bit only if the line is still low at the 8th oversampling tick. A low pulse shorter than that completes no frame, and `rx_full` stays 0.
- R2: After the start bit is confirmed, the block samples each following bit every 16 ticks, which places the sample at the bit centre. Data bits are taken least significant bit first. The received byte appears on `rx_data`.
- R3: In normal mode (`mp_mode`=0) with `len8`=0, the block takes 7 data bits and presents them on `rx_data` with bit 7 forced to 0.
- R4: In multiprocessor mode (`mp_mode`=1) the block takes 8 data bits whatever the value of `len8`. The bit that follows them is captured on `rx_ad`. No parity check is made, and `err_parity` is never set, even with `par_en`=1. In normal mode `rx_ad` reads 0.
- R5: While `rx_en`=0 the receiver stays idle and ignores the line. A full frame sent in that state leaves `rx_full` at 0.
- R6: A stop bit that samples low sets `err_frame`. The error flags and `rx_full` are written on the same clock edge, so the host sees both together.
- R7: In normal mode with `par_en`=1, one parity bit follows the data. With `par_odd`=0 the total count of ones in the data and parity bit must be even. With `par_odd`=1 it must be odd. A mismatch sets `err_parity`.
- R8: Each completed frame sets `rx_full`. A pulse on `rd_strobe` clears it on the next edge. A frame that completes in the same cycle takes priority.
- R9: A pulse on `err_clr` clears `err_frame`, `err_parity` and `err_overrun`. An error raised by a frame completing in that same cycle takes priority.
- R10: When a frame completes while `rx_full` is still 1 and no read is made in that cycle, `err_overrun` is set. `rx_data` then holds the newer frame.
- R11: `rx_irq` is 1 exactly when `rx_full`=1 and `rie`=1.
- R12: After reset, `rx_full`, all three error flags, `rx_irq`, `rx_ad` and `rx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| rx_en | input | 1 | Receiver enable |
| rxd | input | 1 | Serial line, asynchronous |
| mp_mode | input | 1 | 1 = multiprocessor mode |
| len8 | input | 1 | Normal mode: 1 = 8 data bits, 0 = 7 |
| par_en | input | 1 | Normal mode parity enable |
| par_odd | input | 1 | Parity sense: 1 = odd, 0 = even |
| rie | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | Host read of received data, clears `rx_full` |
| err_clr | input | 1 | Clears all error flags |
| rx_data | output | 8 | Last received data byte |
| rx_ad | output | 1 | Captured address/data marker |
| rx_full | output | 1 | Receive-full flag |
| err_frame | output | 1 | Framing error flag |
| err_parity | output | 1 | Parity error flag |
| err_overrun | output | 1 | Overrun error flag |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
Some rules can be checked on every cycle, and the embedded assertions cover these:
- error flags and receive-full rise on the same edge when a frame finishes;
- a read clears receive-full and an error clear empties the error flags;
- a frame that completes over an unread one raises overrun;
- multiprocessor frames never set a parity error;
- a 7-bit frame is zero-extended;
- a disabled receiver drops to idle.

Other behaviour depends on the serial waveform, and only the bench scenarios can show it:
- whether the sampling points land in the bit centres;
- that data arrives least significant bit first;
- that a short glitch is rejected;
- that the parity sense and the marker bit come out right.

// File: rtl/uart_mprx_pkg.sv
package uart_mprx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_EXTRA,
    ST_STOP
  } rx_state_e;

  // Place a shifted-in frame at bit 0; a 7-bit frame sits one place high.
  function automatic logic [7:0] align_data(input logic [7:0] sh, input logic eight);
    return eight ? sh : {1'b0, sh[7:1]};
  endfunction

  // 1 when data plus parity bit disagree with the selected sense.
  function automatic logic parity_bad(input logic [7:0] d, input logic pbit,
                                      input logic odd);
    return (^d) ^ pbit ^ odd;
  endfunction

endpackage

// File: rtl/uart_mprx_sync.sv
module uart_mprx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_mprx_frame.sv
module uart_mprx_frame
  import uart_mprx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic       line,
  input  logic       mp_mode,
  input  logic       len8,
  input  logic       par_en,
  input  logic       par_odd,
  output logic       done,
  output logic [7:0] data,
  output logic       ad,
  output logic       ferr,
  output logic       perr,
  output logic       busy
);
  localparam int CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] MID_C  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(OSR - 1);

  rx_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       bitn;
  logic [7:0]       sh;
  logic             xbit;

  logic eight, use_extra, at_centre;
  logic [2:0] last_bit;
  logic [7:0] frame_byte;

  assign eight      = mp_mode | len8;
  assign use_extra  = mp_mode | par_en;
  assign last_bit   = eight ? 3'd7 : 3'd6;
  assign at_centre  = tick && (cnt == LAST_C);
  assign frame_byte = align_data(sh, eight);
  assign busy       = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      sh    <= '0;
      xbit  <= 1'b0;
      done  <= 1'b0;
      data  <= '0;
      ad    <= 1'b0;
      ferr  <= 1'b0;
      perr  <= 1'b0;
    end else if (!en) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (!line) begin
          state <= ST_START;
          cnt   <= '0;
        end
        ST_START: if (tick) begin
          if (cnt == MID_C) begin
            cnt  <= '0;
            bitn <= '0;
            state <= line ? ST_IDLE : ST_DATA;
          end else cnt <= cnt + 1'b1;
        end
        ST_DATA: if (tick) begin
          if (at_centre) begin
            cnt  <= '0;
            sh   <= {line, sh[7:1]};
            bitn <= bitn + 1'b1;
            if (bitn == last_bit) state <= use_extra ? ST_EXTRA : ST_STOP;
          end else cnt <= cnt + 1'b1;
        end
        ST_EXTRA: if (tick) begin
          if (at_centre) begin
            cnt   <= '0;
            xbit  <= line;
            state <= ST_STOP;
          end else cnt <= cnt + 1'b1;
        end
        ST_STOP: if (tick) begin
          if (at_centre) begin
            cnt   <= '0;
            done  <= 1'b1;
            data  <= frame_byte;
            ad    <= mp_mode & xbit;
            ferr  <= ~line;
            perr  <= ~mp_mode & par_en & parity_bad(frame_byte, xbit, par_odd);
            state <= ST_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: a disabled receiver is idle and completes nothing
  p_disabled_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!busy && !done));

  // R4: multiprocessor frames never report a parity error
  p_mp_no_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mp_mode) |-> !perr);

  // R3: seven-bit normal frames are zero-extended
  p_seven_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mp_mode && !len8) |-> !data[7]);

endmodule

// File: rtl/uart_mprx_status.sv
module uart_mprx_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frm_done,
  input  logic [7:0] frm_data,
  input  logic       frm_ad,
  input  logic       frm_ferr,
  input  logic       frm_perr,
  input  logic       rd_strobe,
  input  logic       err_clr,
  output logic [7:0] rx_data,
  output logic       rx_ad,
  output logic       rx_full,
  output logic       err_frame,
  output logic       err_parity,
  output logic       err_overrun
);
  logic overrun_hit;
  assign overrun_hit = frm_done && rx_full && !rd_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data     <= '0;
      rx_ad       <= 1'b0;
      rx_full     <= 1'b0;
      err_frame   <= 1'b0;
      err_parity  <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      if (frm_done) begin
        rx_data <= frm_data;
        rx_ad   <= frm_ad;
        rx_full <= 1'b1;
      end else if (rd_strobe) begin
        rx_full <= 1'b0;
      end
      err_frame   <= (err_frame   & ~err_clr) | (frm_done & frm_ferr);
      err_parity  <= (err_parity  & ~err_clr) | (frm_done & frm_perr);
      err_overrun <= (err_overrun & ~err_clr) | overrun_hit;
    end
  end

  // R6: framing error and receive-full become visible together
  p_err_with_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && frm_ferr) |=> (err_frame && rx_full));

  // R8: a read with no completing frame empties the flag
  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !frm_done) |=> !rx_full);

  // R10: completion over an unread frame raises overrun
  p_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_hit |=> err_overrun);

  // R9: clear strobe with no completing frame empties all error flags
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !frm_done) |=> (!err_frame && !err_parity && !err_overrun));

endmodule

// File: rtl/uart_mprx.sv
module uart_mprx #(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rx_en,
  input  logic       rxd,
  input  logic       mp_mode,
  input  logic       len8,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       rie,
  input  logic       rd_strobe,
  input  logic       err_clr,
  output logic [7:0] rx_data,
  output logic       rx_ad,
  output logic       rx_full,
  output logic       err_frame,
  output logic       err_parity,
  output logic       err_overrun,
  output logic       rx_irq
);
  logic       line_s;
  logic       frm_done, frm_ad, frm_ferr, frm_perr, frm_busy;
  logic [7:0] frm_data;

  uart_mprx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line_s)
  );

  uart_mprx_frame #(.OSR(OSR)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .en(rx_en), .line(line_s),
    .mp_mode(mp_mode), .len8(len8), .par_en(par_en), .par_odd(par_odd),
    .done(frm_done), .data(frm_data), .ad(frm_ad), .ferr(frm_ferr),
    .perr(frm_perr), .busy(frm_busy)
  );

  uart_mprx_status u_status (
    .clk(clk), .rst_n(rst_n), .frm_done(frm_done), .frm_data(frm_data),
    .frm_ad(frm_ad), .frm_ferr(frm_ferr), .frm_perr(frm_perr),
    .rd_strobe(rd_strobe), .err_clr(err_clr), .rx_data(rx_data),
    .rx_ad(rx_ad), .rx_full(rx_full), .err_frame(err_frame),
    .err_parity(err_parity), .err_overrun(err_overrun)
  );

  assign rx_irq = rx_full & rie;

  // R11: the interrupt never stands without a full receive register
  p_irq_needs_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (rx_full && rie));

  // R1: a frame can only complete after the receiver left idle
  p_done_after_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |-> $past(frm_busy));

endmodule

// File: tb/test_uart_mprx.sv
module test_uart_mprx;
  localparam int TICK_DIV = 2;
  localparam int BITCLK   = 16 * TICK_DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_tick = 1'b0;
  logic rx_en = 1'b0, rxd = 1'b1, mp_mode = 1'b0, len8 = 1'b1;
  logic par_en = 1'b0, par_odd = 1'b0, rie = 1'b0, rd_strobe = 1'b0, err_clr = 1'b0;
  logic [7:0] rx_data;
  logic rx_ad, rx_full, err_frame, err_parity, err_overrun, rx_irq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uart_mprx i_uart_mprx (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_en(rx_en), .rxd(rxd),
    .mp_mode(mp_mode), .len8(len8), .par_en(par_en), .par_odd(par_odd),
    .rie(rie), .rd_strobe(rd_strobe), .err_clr(err_clr), .rx_data(rx_data),
    .rx_ad(rx_ad), .rx_full(rx_full), .err_frame(err_frame),
    .err_parity(err_parity), .err_overrun(err_overrun), .rx_irq(rx_irq)
  );

  always @(negedge clk) os_tick <= ~os_tick;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hold_bit(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  // start, nd data bits LSB first, optional extra bit, stop
  task automatic send(input logic [7:0] d, input int nd, input bit has_x,
                      input logic xb, input logic stop_v);
    hold_bit(1'b0, BITCLK);
    for (int i = 0; i < nd; i++) hold_bit(d[i], BITCLK);
    if (has_x) hold_bit(xb, BITCLK);
    if (stop_v) hold_bit(1'b1, BITCLK);
    else        hold_bit(1'b0, 24);
    hold_bit(1'b1, 40);
  endtask

  task automatic pulse_rd();
    rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_clr();
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
  endtask

  function automatic logic even_bit(input logic [7:0] d);
    return logic'($countones(d) % 2);
  endfunction

  task automatic t_reset();
    chk("R12 rx_full", rx_full, 0);
    chk("R12 errors", {err_frame, err_parity, err_overrun}, 0);
    chk("R12 irq", rx_irq, 0);
    chk("R12 data", rx_data, 0);
    chk("R12 ad", rx_ad, 0);
  endtask

  task automatic t_normal8();
    mp_mode = 0; len8 = 1; par_en = 0; rie = 1;
    send(8'hA5, 8, 0, 0, 1);
    chk("R2 data 0xA5", rx_data, 8'hA5);
    chk("R8 full set", rx_full, 1);
    chk("R11 irq with rie", rx_irq, 1);
    chk("R4 ad zero in normal", rx_ad, 0);
    rie = 0; @(negedge clk);
    chk("R11 irq masked", rx_irq, 0);
    rie = 1;
    pulse_rd();
    chk("R8 read clears", rx_full, 0);
    chk("R11 irq follows full", rx_irq, 0);
    send(8'h3C, 8, 0, 0, 1);
    chk("R2 data 0x3C", rx_data, 8'h3C);
    pulse_rd();
  endtask

  task automatic t_seven();
    len8 = 0;
    send(8'hCD, 7, 0, 0, 1);
    chk("R3 seven-bit data", rx_data, 8'h4D);
    pulse_rd();
    len8 = 1;
  endtask

  task automatic t_parity();
    par_en = 1; par_odd = 0;
    send(8'h96, 8, 1, even_bit(8'h96), 1);
    chk("R7 even ok", err_parity, 0);
    chk("R7 even data", rx_data, 8'h96);
    pulse_rd();
    send(8'h97, 8, 1, ~even_bit(8'h97), 1);
    chk("R7 even bad", err_parity, 1);
    pulse_rd(); pulse_clr();
    chk("R9 clear", err_parity, 0);
    par_odd = 1;
    send(8'h31, 8, 1, ~even_bit(8'h31), 1);
    chk("R7 odd ok", err_parity, 0);
    pulse_rd();
    send(8'h31, 8, 1, even_bit(8'h31), 1);
    chk("R7 odd bad", err_parity, 1);
    pulse_rd(); pulse_clr();
    par_en = 0; par_odd = 0;
  endtask

  task automatic t_mp();
    mp_mode = 1; len8 = 0; par_en = 1;
    send(8'hE1, 8, 1, 1'b1, 1);
    chk("R4 mp data", rx_data, 8'hE1);
    chk("R4 mp ad=1", rx_ad, 1);
    chk("R4 mp no parity err", err_parity, 0);
    pulse_rd();
    send(8'h5A, 8, 1, 1'b0, 1);
    chk("R4 mp ad=0", rx_ad, 0);
    chk("R4 mp data 0x5A", rx_data, 8'h5A);
    chk("R4 mp no parity err 2", err_parity, 0);
    pulse_rd();
    mp_mode = 0; len8 = 1; par_en = 0;
  endtask

  task automatic t_framing();
    send(8'h81, 8, 0, 0, 0);
    chk("R6 frame err", err_frame, 1);
    chk("R6 full with err", rx_full, 1);
    chk("R6 data kept", rx_data, 8'h81);
    pulse_rd(); pulse_clr();
    chk("R9 frame clear", err_frame, 0);
  endtask

  task automatic t_glitch();
    hold_bit(1'b0, 6);
    hold_bit(1'b1, BITCLK * 2);
    chk("R1 glitch rejected", rx_full, 0);
    send(8'h42, 8, 0, 0, 1);
    chk("R1 frame after glitch", rx_data, 8'h42);
    pulse_rd();
  endtask

  task automatic t_disabled();
    rx_en = 0;
    send(8'h77, 8, 0, 0, 1);
    chk("R5 disabled no frame", rx_full, 0);
    chk("R5 disabled data kept", rx_data, 8'h42);
    rx_en = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_overrun();
    send(8'h11, 8, 0, 0, 1);
    send(8'h22, 8, 0, 0, 1);
    chk("R10 overrun", err_overrun, 1);
    chk("R10 newer data", rx_data, 8'h22);
    pulse_rd(); pulse_clr();
    chk("R9 overrun clear", err_overrun, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    rx_en = 1'b1;
    repeat (4) @(negedge clk);
    t_normal8();
    t_seven();
    t_parity();
    t_mp();
    t_framing();
    t_glitch();
    t_disabled();
    t_overrun();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule